// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL waveform for an I2C master and the timing strobes that a byte engine needs. It drives SCL as open drain: it only pulls the line low or releases it. It samples the real SCL and SDA pins back through a two-stage synchronizer and a programmable glitch filter. It has two timing modes. In the symmetric mode one divider value sets all four quarter sub-phases of a period. In the split mode the divider sets the high phase and a second count sets the low phase, which allows a duty cycle other than 50%. In both modes a fixed latency of 15 input clocks is added to the high phase.

The high phase is counted only from the point where the filtered SCL is actually seen high. A slave that holds SCL low therefore stretches the period, and it cannot make the high phase shorter. The configuration is captured at the start of each SCL period, so a change written mid-period only takes effect from the next period. While `run` is low the line is released and no strobes are produced. When `run` falls, the period in progress is completed first.

Top module: `scl_pacer`

## Requirements
- R1: After reset, and while idle with `run` low, `sclDriveLow`, `launchStb` and `sampleStb` are 0. `sclSample` and `sdaSample` reset to 1.
- R2: With `splitEn` = 0, each low phase holds `sclDriveLow` = 1 for exactly 2·D input clocks, where D is `divMain`.
- R3: With `splitEn` = 0, the high phase counts from the first cycle after release in which `sclSample` reads 1. From that cycle, SCL stays released for exactly 15 + 2·D cycles.
- R4: With `splitEn` = 1, the low phase lasts `lowCount` cycles and the counted high phase lasts 15 + D cycles.
- R5: With `splitEn` = 0, the value on `lowCount` has no effect on any phase length.
- R6: A `divMain` or `lowCount` value of 0 behaves as 1.
- R7: The maximum value 4095 is accepted as the slowest setting. In symmetric mode it gives a low phase of 8190 cycles and a high phase of 8205 cycles.
- R8: While a slave holds SCL low after release, `sclDriveLow` stays 0 and the high count does not start. Once SCL is seen high, the full high length still elapses.
- R9: Each low phase of length N has exactly one `launchStb`, in its cycle floor(N/2)+1. Each counted high phase of length M has exactly one `sampleStb`, in its counted cycle floor(M/2)+1.
- R10: Configuration is captured when a period starts. A change applied after that point leaves the current period unchanged and governs the next one.
- R11: Each input passes through a two-flop synchronizer and a filter with setting F (SDA and SCL have separate settings). A level change lasting F cycles or fewer is rejected and one lasting F+1 cycles is accepted. F = 0 passes a one-cycle pulse.
- R12: When `run` falls, the period in progress completes with its normal lengths. After that, SCL stays released and no further strobes appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Keep generating SCL periods while high |
| divMain | input | 12 | Main divider (quarter length, or high length in split mode) |
| lowCount | input | 12 | Low-phase length in split mode |
| splitEn | input | 1 | 1 selects separate high/low counts |
| sdaFiltSel | input | 3 | SDA glitch filter setting, 0 = off |
| sclFiltSel | input | 3 | SCL glitch filter setting, 0 = off |
| sdaIn | input | 1 | SDA pin level |
| sclIn | input | 1 | SCL pin level |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaSample | output | 1 | Synchronized, filtered SDA |
| sclSample | output | 1 | Synchronized, filtered SCL |
| launchStb | output | 1 | One-cycle strobe at the middle of the low phase |
| sampleStb | output | 1 | One-cycle strobe at the middle of the counted high phase |

## Verification
The bench models the bus as a wired-AND of the block's drive and a slave hold. It measures each phase cycle by cycle. Zero divider and low values are included: a design that took zero literally would stall or produce an empty phase. A divider of 4095 is included as well, where a counter that is too narrow would wrap and shorten the period. Configuration is changed in the middle of a running period. A design that applied it at once would show the new lengths one period too early. Slave stretching is also exercised: a design that started the high count at release would pull SCL low too soon after the slave let go. Finally the bench sends filter pulses exactly at the threshold, and an off-by-one filter would pass or reject the wrong pulse.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  // Phase of the SCL period
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,   // released, waiting to see SCL high
    PH_HIGH = 2'd3
  } pacerPhase_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic latchCfg;    // capture configuration (period start)
    logic startPhase;  // next cycle is cycle 1 of a phase
    logic advance;     // increment the phase cycle index
    logic selHigh;     // compare against the high-phase length
  } pacerCmd_t;

  // Datapath -> control status
  typedef struct packed {
    logic lastCycle;
    logic midCycle;
  } pacerStat_t;

endpackage

// File: rtl/scl_pacer_filter.sv
module scl_pacer_filter #(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic [SEL_W-1:0] filtSel,
  output logic             filtOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLvl;
  logic [SEL_W-1:0]       runLen;
  logic                   filtQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= {SYNC_STAGES{IDLE_LEVEL}};
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  assign syncLvl = syncQ[SYNC_STAGES-1];

  // Output follows only after the new level was seen filtSel+1 cycles in a row
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
      filtQ  <= IDLE_LEVEL;
    end else if (syncLvl == filtQ) begin
      runLen <= '0;
    end else if (runLen == filtSel) begin
      filtQ  <= syncLvl;
      runLen <= '0;
    end else begin
      runLen <= runLen + SEL_W'(1);
    end
  end

  assign filtOut = filtQ;

  // R11: the filtered level only ever moves to a level the synchronizer presented
  a_r11_follows_sync: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtQ) |-> ($past(syncLvl) == filtQ));

  // R11: with filtering off, any disagreement is resolved in one cycle
  a_r11_bypass_fast: assert property (@(posedge clk) disable iff (!rstN)
    (filtSel == '0 && syncLvl != filtQ) |=> (filtQ == $past(syncLvl)));

endmodule

// File: rtl/scl_pacer_dp.sv
module scl_pacer_dp
  import scl_pacer_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SEL_W       = 3,
  parameter int HIGH_LAT    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divMain,
  input  logic [DIV_W-1:0] lowCount,
  input  logic             splitEn,
  input  logic [SEL_W-1:0] sdaSel,
  input  logic [SEL_W-1:0] sclSel,
  input  logic             sdaIn,
  input  logic             sclIn,
  input  pacerCmd_t        cmd,
  output pacerStat_t       stat,
  output logic             sdaFilt,
  output logic             sclFilt
);

  localparam int LEN_W = DIV_W + 1;   // 2 x divider
  localparam int CNT_W = DIV_W + 2;   // 2 x divider + latency
  localparam int NPIN  = 2;

  // ---------------- input conditioning ----------------
  logic [NPIN-1:0]       rawBus;
  logic [NPIN-1:0]       filtBus;
  logic [NPIN*SEL_W-1:0] selBus;

  assign rawBus = {sclIn, sdaIn};
  assign selBus = {sclSel, sdaSel};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    scl_pacer_filter #(
      .SEL_W      (SEL_W),
      .SYNC_STAGES(SYNC_STAGES),
      .IDLE_LEVEL (1'b1)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawBus[g]),
      .filtSel(selBus[g*SEL_W +: SEL_W]),
      .filtOut(filtBus[g])
    );
  end

  assign sdaFilt = filtBus[0];
  assign sclFilt = filtBus[1];

  // ---------------- configuration capture ----------------
  logic [DIV_W-1:0] cfgDiv;
  logic [DIV_W-1:0] cfgLow;
  logic             cfgSplit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgDiv   <= DIV_W'(1);
      cfgLow   <= DIV_W'(1);
      cfgSplit <= 1'b0;
    end else if (cmd.latchCfg) begin
      cfgDiv   <= divMain;
      cfgLow   <= lowCount;
      cfgSplit <= splitEn;
    end
  end

  // ---------------- phase lengths ----------------
  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] lowEff;
  logic [LEN_W-1:0] lowLen;
  logic [LEN_W-1:0] hiCore;
  logic [CNT_W-1:0] hiTot;
  logic [CNT_W-1:0] phaseLen;
  logic [CNT_W-1:0] phaseMid;

  always_comb begin
    divEff   = (cfgDiv == '0) ? DIV_W'(1) : cfgDiv;
    lowEff   = (cfgLow == '0) ? DIV_W'(1) : cfgLow;
    lowLen   = cfgSplit ? {1'b0, lowEff} : {divEff, 1'b0};
    hiCore   = cfgSplit ? {1'b0, divEff} : {divEff, 1'b0};
    hiTot    = {1'b0, hiCore} + CNT_W'(HIGH_LAT);
    phaseLen = cmd.selHigh ? hiTot : {1'b0, lowLen};
    phaseMid = (phaseLen >> 1) + CNT_W'(1);
  end

  // ---------------- phase cycle index (1-based) ----------------
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= CNT_W'(1);
    else if (cmd.startPhase) cnt <= CNT_W'(1);
    else if (cmd.advance)    cnt <= cnt + CNT_W'(1);
  end

  assign stat.lastCycle = (cnt == phaseLen);
  assign stat.midCycle  = (cnt == phaseMid);

  // R10: captured configuration only moves at a period start
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.latchCfg |=> ($stable(cfgDiv) && $stable(cfgLow) && $stable(cfgSplit)));

  // R2: the cycle index never runs past the phase it is timing
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= CNT_W'(1)) && (cnt <= phaseLen));

  // R6: every phase length is at least one cycle
  a_r6_len_floor: assert property (@(posedge clk) disable iff (!rstN)
    (lowLen != '0) && (hiTot > CNT_W'(HIGH_LAT)));

endmodule

// File: rtl/scl_pacer_ctrl.sv
module scl_pacer_ctrl
  import scl_pacer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       sclSeen,
  input  pacerStat_t stat,
  output pacerCmd_t  cmd,
  output logic       sclDriveLow,
  output logic       launchStb,
  output logic       sampleStb
);

  pacerPhase_t state;
  pacerPhase_t nxt;
  logic        periodEnd;

  always_comb begin
    nxt         = state;
    cmd         = '0;
    periodEnd   = 1'b0;
    cmd.selHigh = (state == PH_WAIT) || (state == PH_HIGH);
    unique case (state)
      PH_IDLE: begin
        if (run) begin
          nxt            = PH_LOW;
          cmd.latchCfg   = 1'b1;
          cmd.startPhase = 1'b1;
        end
      end
      PH_LOW: begin
        if (stat.lastCycle) begin
          nxt            = PH_WAIT;
          cmd.startPhase = 1'b1;
        end else begin
          cmd.advance = 1'b1;
        end
      end
      PH_WAIT: begin
        // index stays at 1 until SCL is seen high; that cycle is cycle 1
        if (sclSeen) begin
          if (stat.lastCycle) begin
            periodEnd = 1'b1;
          end else begin
            nxt         = PH_HIGH;
            cmd.advance = 1'b1;
          end
        end
      end
      PH_HIGH: begin
        if (stat.lastCycle) periodEnd = 1'b1;
        else                cmd.advance = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
    if (periodEnd) begin
      cmd.startPhase = 1'b1;
      if (run) begin
        nxt          = PH_LOW;
        cmd.latchCfg = 1'b1;
      end else begin
        nxt = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nxt;
  end

  assign sclDriveLow = (state == PH_LOW);
  assign launchStb   = (state == PH_LOW) && stat.midCycle;
  assign sampleStb   = (((state == PH_WAIT) && sclSeen) || (state == PH_HIGH)) && stat.midCycle;

  // R8: while the line is still seen low after release, keep waiting released
  a_r8_stretch_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAIT && !sclSeen) |=> (state == PH_WAIT));

  // R2: the low phase is never cut short
  a_r2_low_not_cut: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_LOW && !stat.lastCycle) |=> (state == PH_LOW));

  // R9: strobes last exactly one cycle
  a_r9_launch_single: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |=> !launchStb);
  a_r9_sample_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

  // R1: idle persists while run is low
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && !run) |=> (state == PH_IDLE && !sclDriveLow));

  // R12: a period always ends through the high phase before going idle
  a_r12_stop_after_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && $past(state) != PH_IDLE) |-> ($past(state) == PH_HIGH || $past(state) == PH_WAIT));

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SEL_W       = 3,
  parameter int HIGH_LAT    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divMain,
  input  logic [DIV_W-1:0] lowCount,
  input  logic             splitEn,
  input  logic [SEL_W-1:0] sdaFiltSel,
  input  logic [SEL_W-1:0] sclFiltSel,
  input  logic             sdaIn,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             sdaSample,
  output logic             sclSample,
  output logic             launchStb,
  output logic             sampleStb
);

  pacerCmd_t  cmd;
  pacerStat_t stat;
  logic       sclFilt;
  logic       sdaFilt;

  scl_pacer_dp #(
    .DIV_W      (DIV_W),
    .SEL_W      (SEL_W),
    .HIGH_LAT   (HIGH_LAT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .divMain (divMain),
    .lowCount(lowCount),
    .splitEn (splitEn),
    .sdaSel  (sdaFiltSel),
    .sclSel  (sclFiltSel),
    .sdaIn   (sdaIn),
    .sclIn   (sclIn),
    .cmd     (cmd),
    .stat    (stat),
    .sdaFilt (sdaFilt),
    .sclFilt (sclFilt)
  );

  scl_pacer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .sclSeen    (sclFilt),
    .stat       (stat),
    .cmd        (cmd),
    .sclDriveLow(sclDriveLow),
    .launchStb  (launchStb),
    .sampleStb  (sampleStb)
  );

  assign sdaSample = sdaFilt;
  assign sclSample = sclFilt;

endmodule

// File: tb/test_scl_pacer.sv
module test_scl_pacer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic [11:0] divMain = 12'd5;
  logic [11:0] lowCount = 12'd0;
  logic        splitEn = 1'b0;
  logic [2:0]  sdaFiltSel = 3'd0;
  logic [2:0]  sclFiltSel = 3'd0;
  logic        sdaIn = 1'b1;
  logic        slaveHold = 1'b0;
  logic        sclIn;
  logic        sclDriveLow, sdaSample, sclSample, launchStb, sampleStb;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  assign sclIn = ~(sclDriveLow | slaveHold);   // wired-AND bus

  scl_pacer i_scl_pacer (
    .clk(clk), .rstN(rstN), .run(run), .divMain(divMain), .lowCount(lowCount),
    .splitEn(splitEn), .sdaFiltSel(sdaFiltSel), .sclFiltSel(sclFiltSel),
    .sdaIn(sdaIn), .sclIn(sclIn), .sclDriveLow(sclDriveLow), .sdaSample(sdaSample),
    .sclSample(sclSample), .launchStb(launchStb), .sampleStb(sampleStb)
  );

  typedef struct packed {
    logic        split;
    logic [11:0] div;
    logic [11:0] low;
    int unsigned expLow;
    int unsigned expHigh;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'd5,    12'd33, 10,   25},    // R2 R3 R5
    '{1'b1, 12'd8,    12'd20, 20,   23},    // R4
    '{1'b0, 12'd1,    12'd7,  2,    17},    // R2 R5
    '{1'b1, 12'd3,    12'd1,  1,    18},    // R4 short low
    '{1'b0, 12'd0,    12'd9,  2,    17},    // R6
    '{1'b1, 12'd0,    12'd0,  1,    16},    // R6
    '{1'b1, 12'd100,  12'd37, 37,   115},   // R4
    '{1'b0, 12'd4095, 12'd0,  8190, 8205}   // R7
  };

  task automatic chk(input string req, input int actual, input int expected, input string what);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // Precondition: sampled at the first cycle of a low phase.
  task automatic measure(input int holdCycles, output int lowN, output int hiN,
                         output int launchAt, output int sampleAt,
                         output int launchCnt, output int sampleCnt, output int heldRel);
    int guard = 0;
    int elapsed = 0;
    bit started = 1'b0;
    lowN = 0; hiN = 0; launchAt = 0; sampleAt = 0;
    launchCnt = 0; sampleCnt = 0; heldRel = 0;
    if (holdCycles > 0) slaveHold = 1'b1;
    while (sclDriveLow && guard < 20000) begin
      guard++;
      lowN++;
      if (launchStb) begin launchCnt++; launchAt = lowN; end
      if (sampleStb) sampleCnt++;
      @(negedge clk);
    end
    while (!sclDriveLow && guard < 40000) begin
      guard++;
      if (elapsed == holdCycles) slaveHold = 1'b0;
      if (slaveHold) heldRel++;
      elapsed++;
      if (sclSample) started = 1'b1;
      if (started) hiN++;
      if (sampleStb) begin sampleCnt++; sampleAt = hiN; end
      if (launchStb) launchCnt++;
      @(negedge clk);
    end
  endtask

  task automatic checkPeriod(input string req, input int expLow, input int expHigh, input int holdCycles);
    int lN, hN, lA, sA, lC, sC, hR;
    measure(holdCycles, lN, hN, lA, sA, lC, sC, hR);
    chk(req, lN, expLow, "low length");
    chk(req, hN, expHigh, "high length");
    chk("R9", lA, expLow / 2 + 1, "launch position");
    chk("R9", sA, expHigh / 2 + 1, "sample position");
    chk("R9", lC * 10 + sC, 11, "strobe counts (launch*10+sample)");
    if (holdCycles > 0) chk("R8", hR, holdCycles, "released cycles under slave hold");
  endtask

  task automatic waitLow();
    int g = 0;
    while (!sclDriveLow && g < 40000) begin g++; @(negedge clk); end
  endtask

  // pulse on SDA from level 1 to 0 for w cycles; return whether sdaSample dropped
  task automatic sdaPulse(input int w, output bit seen);
    seen = 1'b0;
    sdaIn = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i == w) sdaIn = 1'b1;
      @(negedge clk);
      if (!sdaSample) seen = 1'b1;
    end
  endtask

  task automatic sclPulse(input int w, output bit seen);
    seen = 1'b0;
    slaveHold = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (i == w) slaveHold = 1'b0;
      @(negedge clk);
      if (!sclSample) seen = 1'b1;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int prevLow, prevHigh;
    bit seen;
    int bad;

    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1: idle after reset
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclDriveLow || launchStb || sampleStb || !sclSample || !sdaSample) bad++;
    end
    chk("R1", bad, 0, "idle cycles with activity after reset");

    // R11: filter thresholds while idle
    sdaFiltSel = 3'd3;
    sdaPulse(3, seen); chk("R11", seen, 0, "SDA 3-cycle pulse with setting 3");
    sdaPulse(4, seen); chk("R11", seen, 1, "SDA 4-cycle pulse with setting 3");
    sdaFiltSel = 3'd0;
    sdaPulse(1, seen); chk("R11", seen, 1, "SDA 1-cycle pulse unfiltered");
    sclFiltSel = 3'd2;
    sclPulse(2, seen); chk("R11", seen, 0, "SCL 2-cycle pulse with setting 2");
    sclPulse(3, seen); chk("R11", seen, 1, "SCL 3-cycle pulse with setting 2");
    sclFiltSel = 3'd0;
    repeat (10) @(negedge clk);

    // Vector table: each period after a change still shows the old setting (R10)
    splitEn = VECS[0].split; divMain = VECS[0].div; lowCount = VECS[0].low;
    run = 1'b1;
    waitLow();
    prevLow = VECS[0].expLow;
    prevHigh = VECS[0].expHigh;
    for (int v = 0; v < NVEC; v++) begin
      splitEn = VECS[v].split; divMain = VECS[v].div; lowCount = VECS[v].low;
      checkPeriod("R10", prevLow, prevHigh, 0);
      checkPeriod(VECS[v].split ? "R4" : "R2/R3", VECS[v].expLow, VECS[v].expHigh, 0);
      prevLow = VECS[v].expLow;
      prevHigh = VECS[v].expHigh;
    end

    // R5: legacy mode ignores lowCount, check two values back to back
    splitEn = 1'b0; divMain = 12'd3; lowCount = 12'd200;
    checkPeriod("R10", prevLow, prevHigh, 0);
    checkPeriod("R5", 6, 21, 0);
    lowCount = 12'd1;
    checkPeriod("R5", 6, 21, 0);
    checkPeriod("R5", 6, 21, 0);

    // R8: slave holds SCL low for 30 cycles after release
    splitEn = 1'b1; divMain = 12'd4; lowCount = 12'd6;
    checkPeriod("R10", 6, 21, 0);
    checkPeriod("R8", 6, 19, 30);
    checkPeriod("R8", 6, 19, 0);

    // R12: stop requested during a low phase
    run = 1'b0;
    bad = 0;
    begin
      int lowN = 0;
      int sCnt = 0;
      int lCnt = 0;
      while (sclDriveLow) begin
        lowN++;
        if (launchStb) lCnt++;
        @(negedge clk);
      end
      chk("R12", lowN, 6, "final low length");
      for (int i = 0; i < 300; i++) begin
        if (sclDriveLow) bad++;
        if (launchStb) lCnt++;
        if (sampleStb) sCnt++;
        @(negedge clk);
      end
      chk("R12", bad, 0, "cycles driven low after stop");
      chk("R12", lCnt * 10 + sCnt, 11, "strobes of final period (launch*10+sample)");
      chk("R1", sclSample, 1, "SCL released while idle");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule